// File: doc/BRIEF.md
# Pin-Triggered Secure Erase Sequencer

This block turns a single active-low emergency input into a complete flash sanitise run. The input is synchronised and deglitched. While it stays low, its hold time is counted in milliseconds, using a prescaler of `TICKS_PER_MS` clock cycles. When the input is released, the hold time selects one of three outcomes: a short press is discarded as accidental, a medium press wipes the user area, and a long press also wipes the firmware region.

A trigger is accepted only if the host-transfer state permits it. In master mode, only simultaneous read and write blocks the trigger. In slave mode, any transfer blocks it. Once a run is accepted, the sequencer walks the blocks in ascending order. For each block it requests an erase and then a fill with all-ones over a valid/acknowledge command port. After each block it writes a checkpoint through a second valid/acknowledge port.

At reset, the block samples a stored checkpoint. If that checkpoint shows an unfinished run, the run continues from the saved block before any new trigger is looked at. When a run completes, the block raises a done pulse and an uninitialised flag. The flag stays set until a format request clears it.

Top module: `secure_erase_seq`

## Requirements
- R1: A release after a low hold of fewer than `DATA_MS` whole milliseconds starts nothing. `busy_o` stays low and no command is issued.
- R2: A hold of at least `DATA_MS` but fewer than `FULL_MS` milliseconds wipes blocks 0 to `USER_BLOCKS-1`, with `ckpt_full_o`=0.
- R3: A hold of `FULL_MS` or more milliseconds wipes blocks 0 to `USER_BLOCKS+FW_BLOCKS-1`, with `ckpt_full_o`=1. The hold count saturates at `FULL_MS`.
- R4: The level is decided only at release. The hold count in milliseconds is floor(low cycles / `TICKS_PER_MS`), and nothing starts while the input is still low.
- R5: A change of the filtered input level that lasts fewer than `GLITCH_CYC` cycles is ignored, so a short high blip inside a hold does not split it.
- R6: With `master_mode_i`=1, a release is rejected only if `host_rd_i` and `host_wr_i` are both high at release.
- R7: With `master_mode_i`=0, a release is rejected if `host_rd_i` or `host_wr_i` is high at release.
- R8: For each block, an erase command (`cmd_op_o`=0) is followed by a fill command (`cmd_op_o`=1), and blocks are processed in ascending order. `cmd_valid_o`, `cmd_op_o` and `cmd_blk_o` hold steady until `cmd_ack_i`.
- R9: After the fill of block b is acknowledged, a checkpoint is offered with `ckpt_blk_o`=b+1. It carries `ckpt_active_o`=0 only for the last block (1 otherwise) and `ckpt_full_o` equal to the run level, and it is held until `ckpt_ack_i`.
- R10: If `resume_valid_i` is high at reset release, the run restarts at `resume_blk_i` with the level taken from `resume_full_i`, and `busy_o` rises in the first cycle.
- R11: `busy_o` is high from acceptance until the last checkpoint is acknowledged. `done_o` is then a one-cycle pulse, raised while `busy_o` is low.
- R12: `uninit_o` is set when the run completes and stays set until `format_i` is raised while the block is idle.
- R13: A release that occurs while a run is in progress is ignored, and the running wipe is not restarted or extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| erase_n_i | input | 1 | Emergency erase pin, active low, asynchronous |
| master_mode_i | input | 1 | 1 = master acceptance rule, 0 = slave rule |
| host_rd_i | input | 1 | Host read transfer active |
| host_wr_i | input | 1 | Host write transfer active |
| cmd_valid_o | output | 1 | Flash command request |
| cmd_op_o | output | 1 | 0 = erase block, 1 = fill block with all-ones |
| cmd_blk_o | output | BLK_W | Target block |
| cmd_ack_i | input | 1 | Command accepted |
| ckpt_valid_o | output | 1 | Checkpoint write request |
| ckpt_blk_o | output | BLK_W | Next block to process |
| ckpt_active_o | output | 1 | Run still unfinished |
| ckpt_full_o | output | 1 | Run includes firmware region |
| ckpt_ack_i | input | 1 | Checkpoint stored |
| resume_valid_i | input | 1 | Stored checkpoint shows an unfinished run |
| resume_blk_i | input | BLK_W | Stored next block |
| resume_full_i | input | 1 | Stored level |
| format_i | input | 1 | Clears the uninitialised flag |
| busy_o | output | 1 | Wipe in progress |
| done_o | output | 1 | One-cycle completion pulse |
| uninit_o | output | 1 | Media wiped, not yet formatted |

## Verification
The bench goes after the hold-length boundaries on both sides of each threshold, and a hold far past the upper threshold. A classifier that is off by one tick, or that decides before release, would start the wrong depth or start early. It splits a long hold with a sub-filter blip. A design that skips filtering would see two medium holds and wipe only user data. It crosses the mode and traffic inputs, where a swapped acceptance rule accepts or rejects the wrong cases. It cuts power mid-run and checks that the restart begins at the saved block, with neither repeated nor skipped blocks. It also releases a second hold during a run, which a design that fails to ignore it would use to restart from block 0.

// File: rtl/se_pkg.sv
package se_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_DATA = 2'd1,
    LVL_FULL = 2'd2
  } erase_lvl_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_ERASE,
    ST_FILL,
    ST_CKPT
  } eng_state_e;

  localparam logic OP_ERASE = 1'b0;
  localparam logic OP_FILL  = 1'b1;
endpackage

// File: rtl/se_pin_filter.sv
module se_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_n_i,
  output logic pin_low_o
);
  localparam int CW = $clog2(GLITCH_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   filt_q;
  logic [CW-1:0]          cnt_q;
  logic                   sync_out;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= pin_n_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
    end
  endgenerate

  assign sync_out = sync_q[SYNC_STAGES-1];

  // level must differ for GLITCH_CYC consecutive cycles before it is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else if (sync_out == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(GLITCH_CYC - 1)) begin
      filt_q <= sync_out;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pin_low_o = ~filt_q;
endmodule

// File: rtl/se_hold_timer.sv
module se_hold_timer
  import se_pkg::*;
#(
  parameter int TICKS_PER_MS = 125000,
  parameter int DATA_MS      = 3000,
  parameter int FULL_MS      = 8000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_low_i,
  output logic       release_o,
  output erase_lvl_e level_o
);
  localparam int PW = $clog2(TICKS_PER_MS + 1);
  localparam int MW = $clog2(FULL_MS + 1);

  logic [PW-1:0] pre_q;
  logic [MW-1:0] ms_q;
  logic          low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ms_q  <= '0;
      low_q <= 1'b0;
    end else begin
      low_q <= pin_low_i;
      if (!pin_low_i) begin
        pre_q <= '0;
        ms_q  <= '0;
      end else if (pre_q == PW'(TICKS_PER_MS - 1)) begin
        pre_q <= '0;
        if (ms_q != MW'(FULL_MS)) ms_q <= ms_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign release_o = low_q & ~pin_low_i;

  always_comb begin
    if (ms_q >= MW'(FULL_MS))      level_o = LVL_FULL;
    else if (ms_q >= MW'(DATA_MS)) level_o = LVL_DATA;
    else                           level_o = LVL_NONE;
  end
endmodule

// File: rtl/se_wipe_engine.sv
module se_wipe_engine
  import se_pkg::*;
#(
  parameter int USER_BLOCKS = 4096,
  parameter int FW_BLOCKS   = 64,
  parameter int BW          = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          start_full_i,
  input  logic          resume_valid_i,
  input  logic [BW-1:0] resume_blk_i,
  input  logic          resume_full_i,
  output logic          cmd_valid_o,
  output logic          cmd_op_o,
  output logic [BW-1:0] cmd_blk_o,
  input  logic          cmd_ack_i,
  output logic          ckpt_valid_o,
  output logic [BW-1:0] ckpt_blk_o,
  output logic          ckpt_active_o,
  output logic          ckpt_full_o,
  input  logic          ckpt_ack_i,
  output logic          busy_o,
  output logic          done_o
);
  localparam int TOT = USER_BLOCKS + FW_BLOCKS;
  localparam logic [BW-1:0] LAST_USER = BW'(USER_BLOCKS - 1);
  localparam logic [BW-1:0] LAST_ALL  = BW'(TOT - 1);

  eng_state_e    state_q;
  logic [BW-1:0] blk_q;
  logic          full_q;
  logic          done_q;
  logic          is_last;

  assign is_last = blk_q == (full_q ? LAST_ALL : LAST_USER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
      blk_q   <= '0;
      full_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_BOOT: begin
          // stored checkpoint wins over any new trigger
          if (resume_valid_i) begin
            state_q <= ST_ERASE;
            blk_q   <= resume_blk_i;
            full_q  <= resume_full_i;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_ERASE;
            blk_q   <= '0;
            full_q  <= start_full_i;
          end
        end
        ST_ERASE: if (cmd_ack_i) state_q <= ST_FILL;
        ST_FILL:  if (cmd_ack_i) state_q <= ST_CKPT;
        ST_CKPT: begin
          if (ckpt_ack_i) begin
            if (is_last) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              blk_q   <= blk_q + 1'b1;
              state_q <= ST_ERASE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o   = (state_q == ST_ERASE) || (state_q == ST_FILL);
  assign cmd_op_o      = (state_q == ST_FILL) ? OP_FILL : OP_ERASE;
  assign cmd_blk_o     = blk_q;
  assign ckpt_valid_o  = state_q == ST_CKPT;
  assign ckpt_blk_o    = blk_q + 1'b1;
  assign ckpt_active_o = ~is_last;
  assign ckpt_full_o   = full_q;
  assign busy_o        = cmd_valid_o || ckpt_valid_o;
  assign done_o        = done_q;
endmodule

// File: rtl/secure_erase_seq.sv
module secure_erase_seq
  import se_pkg::*;
#(
  parameter int TICKS_PER_MS = 125000,
  parameter int DATA_MS      = 3000,
  parameter int FULL_MS      = 8000,
  parameter int GLITCH_CYC   = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int USER_BLOCKS  = 4096,
  parameter int FW_BLOCKS    = 64,
  localparam int BLK_W       = $clog2(USER_BLOCKS + FW_BLOCKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             erase_n_i,
  input  logic             master_mode_i,
  input  logic             host_rd_i,
  input  logic             host_wr_i,
  output logic             cmd_valid_o,
  output logic             cmd_op_o,
  output logic [BLK_W-1:0] cmd_blk_o,
  input  logic             cmd_ack_i,
  output logic             ckpt_valid_o,
  output logic [BLK_W-1:0] ckpt_blk_o,
  output logic             ckpt_active_o,
  output logic             ckpt_full_o,
  input  logic             ckpt_ack_i,
  input  logic             resume_valid_i,
  input  logic [BLK_W-1:0] resume_blk_i,
  input  logic             resume_full_i,
  input  logic             format_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             uninit_o
);
  logic       pin_low;
  logic       rel;
  erase_lvl_e lvl;
  logic       traffic_ok;
  logic       start;
  logic       uninit_q;

  se_pin_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .GLITCH_CYC (GLITCH_CYC)
  ) i_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_n_i  (erase_n_i),
    .pin_low_o(pin_low)
  );

  se_hold_timer #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .DATA_MS     (DATA_MS),
    .FULL_MS     (FULL_MS)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_low_i(pin_low),
    .release_o(rel),
    .level_o  (lvl)
  );

  // master tolerates one direction of traffic, slave tolerates none
  assign traffic_ok = master_mode_i ? ~(host_rd_i & host_wr_i)
                                    : ~(host_rd_i | host_wr_i);
  assign start      = rel && (lvl != LVL_NONE) && traffic_ok && !busy_o;

  se_wipe_engine #(
    .USER_BLOCKS(USER_BLOCKS),
    .FW_BLOCKS  (FW_BLOCKS),
    .BW         (BLK_W)
  ) i_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .start_full_i  (lvl == LVL_FULL),
    .resume_valid_i(resume_valid_i),
    .resume_blk_i  (resume_blk_i),
    .resume_full_i (resume_full_i),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_op_o      (cmd_op_o),
    .cmd_blk_o     (cmd_blk_o),
    .cmd_ack_i     (cmd_ack_i),
    .ckpt_valid_o  (ckpt_valid_o),
    .ckpt_blk_o    (ckpt_blk_o),
    .ckpt_active_o (ckpt_active_o),
    .ckpt_full_o   (ckpt_full_o),
    .ckpt_ack_i    (ckpt_ack_i),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    uninit_q <= 1'b0;
    else if (done_o)                uninit_q <= 1'b1;
    else if (format_i && !busy_o)   uninit_q <= 1'b0;
  end

  assign uninit_o = uninit_q;
endmodule

// File: rtl/se_erase_chk.sv
module se_erase_chk #(
  parameter int TOT_BLOCKS = 8,
  parameter int BLK_W      = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_o,
  input logic             cmd_op_o,
  input logic [BLK_W-1:0] cmd_blk_o,
  input logic             cmd_ack_i,
  input logic             ckpt_valid_o,
  input logic [BLK_W-1:0] ckpt_blk_o,
  input logic             ckpt_ack_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             uninit_o
);
  // R8
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_blk_o));

  // R8
  cmd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (32'(cmd_blk_o) < TOT_BLOCKS));

  // R9
  ckpt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ckpt_valid_o && !ckpt_ack_i |=> ckpt_valid_o && $stable(ckpt_blk_o));

  // R9
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && ckpt_valid_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R11
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o || ckpt_valid_o) |-> busy_o);

  // R12
  uninit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> uninit_o);
endmodule

bind secure_erase_seq se_erase_chk #(
  .TOT_BLOCKS(USER_BLOCKS + FW_BLOCKS),
  .BLK_W     (BLK_W)
) i_se_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_o (cmd_valid_o),
  .cmd_op_o    (cmd_op_o),
  .cmd_blk_o   (cmd_blk_o),
  .cmd_ack_i   (cmd_ack_i),
  .ckpt_valid_o(ckpt_valid_o),
  .ckpt_blk_o  (ckpt_blk_o),
  .ckpt_ack_i  (ckpt_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .uninit_o    (uninit_o)
);

// File: tb/test_secure_erase_seq.sv
module test_secure_erase_seq;
  localparam int TPM   = 4;
  localparam int DMS   = 3;
  localparam int FMS   = 8;
  localparam int GL    = 3;
  localparam int UB    = 4;
  localparam int FB    = 2;
  localparam int BLK_W = $clog2(UB + FB + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic erase_n = 1'b1;
  logic master_mode = 1'b1, host_rd = 1'b0, host_wr = 1'b0;
  logic cmd_valid, cmd_op, cmd_ack = 1'b0;
  logic [BLK_W-1:0] cmd_blk, ckpt_blk;
  logic ckpt_valid, ckpt_active, ckpt_full, ckpt_ack = 1'b0;
  logic resume_valid = 1'b0, resume_full = 1'b0;
  logic [BLK_W-1:0] resume_blk = '0;
  logic format = 1'b0;
  logic busy, done, uninit;

  int checks = 0, errors = 0;
  int cmd_cnt = 0, ckpt_cnt = 0;
  int op_log[64], blk_log[64], cb_log[64], ca_log[64], cf_log[64];
  int resp_delay = 2;
  bit resp_fixed = 1'b0;
  int st_blk = 0, st_act = 0, st_full = 0;

  always #4 clk = ~clk;

  secure_erase_seq #(
    .TICKS_PER_MS(TPM), .DATA_MS(DMS), .FULL_MS(FMS), .GLITCH_CYC(GL),
    .SYNC_STAGES(2), .USER_BLOCKS(UB), .FW_BLOCKS(FB)
  ) i_secure_erase_seq (
    .clk_i(clk), .rst_ni(rst_ni), .erase_n_i(erase_n),
    .master_mode_i(master_mode), .host_rd_i(host_rd), .host_wr_i(host_wr),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_blk_o(cmd_blk), .cmd_ack_i(cmd_ack),
    .ckpt_valid_o(ckpt_valid), .ckpt_blk_o(ckpt_blk), .ckpt_active_o(ckpt_active),
    .ckpt_full_o(ckpt_full), .ckpt_ack_i(ckpt_ack),
    .resume_valid_i(resume_valid), .resume_blk_i(resume_blk), .resume_full_i(resume_full),
    .format_i(format), .busy_o(busy), .done_o(done), .uninit_o(uninit)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_level(input int hold);
    if (hold >= FMS * TPM) return 2;
    if (hold >= DMS * TPM) return 1;
    return 0;
  endfunction

  function automatic int exp_accept(input int lvl, input bit m, input bit rd, input bit wr);
    if (lvl == 0) return 0;
    return m ? int'(!(rd && wr)) : int'(!(rd || wr));
  endfunction

  // flash command responder
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid && rst_ni) begin
        int d;
        d = resp_fixed ? resp_delay : int'($urandom_range(resp_delay));
        repeat (d) @(negedge clk);
        if (cmd_valid && rst_ni) begin
          if (cmd_cnt < 64) begin
            op_log[cmd_cnt]  = int'(cmd_op);
            blk_log[cmd_cnt] = int'(cmd_blk);
          end
          cmd_cnt++;
          cmd_ack = 1'b1;
          @(negedge clk);
          cmd_ack = 1'b0;
        end
      end
    end
  end

  // checkpoint store model
  initial begin
    forever begin
      @(negedge clk);
      if (ckpt_valid && rst_ni) begin
        int d;
        d = resp_fixed ? resp_delay : int'($urandom_range(resp_delay));
        repeat (d) @(negedge clk);
        if (ckpt_valid && rst_ni) begin
          if (ckpt_cnt < 64) begin
            cb_log[ckpt_cnt] = int'(ckpt_blk);
            ca_log[ckpt_cnt] = int'(ckpt_active);
            cf_log[ckpt_cnt] = int'(ckpt_full);
          end
          st_blk = int'(ckpt_blk); st_act = int'(ckpt_active); st_full = int'(ckpt_full);
          ckpt_cnt++;
          ckpt_ack = 1'b1;
          @(negedge clk);
          ckpt_ack = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // drive low for exactly n cycles; nothing may start before release (R4)
  task automatic hold_pin(input int n);
    @(negedge clk);
    erase_n = 1'b0;
    repeat (n) @(negedge clk);
    check("R4 no start before release", int'(busy), 0);
    erase_n = 1'b1;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check("R11 done seen", int'(done), 1);
    check("R11 busy low at done", int'(busy), 0);
    @(negedge clk);
    check("R11 done single cycle", int'(done), 0);
    check("R12 uninit set", int'(uninit), 1);
  endtask

  task automatic check_logs(input int s, input int last, input int full);
    int bad = 0;
    check("R8 command count", cmd_cnt, 2 * (last - s + 1));
    check("R9 checkpoint count", ckpt_cnt, last - s + 1);
    for (int k = 0; k < cmd_cnt && k < 64; k++)
      if (op_log[k] != (k % 2) || blk_log[k] != s + k / 2) bad++;
    check("R8 erase-then-fill ascending order", bad, 0);
    bad = 0;
    for (int j = 0; j < ckpt_cnt && j < 64; j++)
      if (cb_log[j] != s + j + 1 || ca_log[j] != int'(s + j != last) || cf_log[j] != full) bad++;
    check("R9 checkpoint contents", bad, 0);
  endtask

  task automatic do_format();
    @(negedge clk);
    format = 1'b1;
    @(negedge clk);
    format = 1'b0;
    @(negedge clk);
    check("R12 format clears uninit", int'(uninit), 0);
  endtask

  task automatic run_trial(input string req, input int hold, input bit m, input bit rd, input bit wr);
    int lvl, acc;
    master_mode = m; host_rd = rd; host_wr = wr;
    cmd_cnt = 0; ckpt_cnt = 0;
    lvl = exp_level(hold);
    acc = exp_accept(lvl, m, rd, wr);
    hold_pin(hold);
    repeat (12) @(negedge clk);
    check({req, " accept"}, int'(busy), acc);
    host_rd = 1'b0; host_wr = 1'b0;
    if (acc != 0) begin
      wait_done();
      check_logs(0, (lvl == 2) ? UB + FB - 1 : UB - 1, int'(lvl == 2));
      do_format();
    end else begin
      repeat (4) @(negedge clk);
      check({req, " no command"}, cmd_cnt, 0);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R11 reset busy", int'(busy), 0);
    check("R8 reset cmd_valid", int'(cmd_valid), 0);
    check("R9 reset ckpt_valid", int'(ckpt_valid), 0);
    check("R11 reset done", int'(done), 0);
    check("R12 reset uninit", int'(uninit), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 no resume stays idle", int'(busy), 0);

    // thresholds
    run_trial("R1 hold 11", 11, 1'b1, 1'b0, 1'b0);
    run_trial("R2 hold 12", 12, 1'b1, 1'b0, 1'b0);
    run_trial("R2 hold 31", 31, 1'b1, 1'b0, 1'b0);
    run_trial("R3 hold 32", 32, 1'b1, 1'b0, 1'b0);
    run_trial("R3 hold 70 saturated", 70, 1'b1, 1'b0, 1'b0);

    // acceptance rules
    run_trial("R6 master rd+wr", 20, 1'b1, 1'b1, 1'b1);
    run_trial("R6 master rd only", 20, 1'b1, 1'b1, 1'b0);
    run_trial("R7 slave wr only", 20, 1'b0, 1'b0, 1'b1);
    run_trial("R7 slave rd only", 40, 1'b0, 1'b1, 1'b0);
    run_trial("R7 slave quiet", 20, 1'b0, 1'b0, 1'b0);

    // R5: 20 low, 2 high blip, 20 low -> one 42-cycle hold, full wipe
    master_mode = 1'b1;
    cmd_cnt = 0; ckpt_cnt = 0;
    @(negedge clk); erase_n = 1'b0;
    repeat (20) @(negedge clk); erase_n = 1'b1;
    repeat (2) @(negedge clk);  erase_n = 1'b0;
    repeat (20) @(negedge clk);
    check("R5 nothing started by blip", int'(busy), 0);
    erase_n = 1'b1;
    repeat (12) @(negedge clk);
    check("R5 filtered hold accepted", int'(busy), 1);
    wait_done();
    check_logs(0, UB + FB - 1, 1);
    do_format();

    // R13: release during a run is ignored
    resp_fixed = 1'b1; resp_delay = 8;
    cmd_cnt = 0; ckpt_cnt = 0;
    hold_pin(16);
    repeat (12) @(negedge clk);
    check("R13 first run started", int'(busy), 1);
    @(negedge clk); erase_n = 1'b0;
    repeat (40) @(negedge clk);
    check("R13 still busy during second hold", int'(busy), 1);
    erase_n = 1'b1;
    wait_done();
    check_logs(0, UB - 1, 0);
    repeat (20) @(negedge clk);
    check("R13 no restart", int'(busy), 0);
    check("R13 no extra commands", cmd_cnt, 2 * UB);
    do_format();

    // R10: power loss mid-run, resume from stored checkpoint
    resp_delay = 4;
    cmd_cnt = 0; ckpt_cnt = 0;
    hold_pin(40);
    begin
      int n = 0;
      while (ckpt_cnt < 2 && n < 2000) begin
        @(negedge clk);
        n++;
      end
    end
    rst_ni = 1'b0;
    @(negedge clk);
    cmd_cnt = 0; ckpt_cnt = 0;
    check("R10 stored checkpoint block", st_blk, 2);
    resume_valid = st_act[0];
    resume_blk   = BLK_W'(st_blk);
    resume_full  = st_full[0];
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R10 busy right after reset", int'(busy), 1);
    check("R10 first block resumed", int'(cmd_blk), 2);
    wait_done();
    check_logs(2, UB + FB - 1, 1);
    resume_valid = 1'b0;
    do_format();

    // constrained random trials
    resp_fixed = 1'b0; resp_delay = 3;
    for (int t = 0; t < 14; t++) begin
      int h;
      bit m, rd, wr;
      h  = 5 + int'($urandom_range(40));
      m  = 1'($urandom_range(1));
      rd = 1'($urandom_range(1));
      wr = 1'($urandom_range(1));
      run_trial("R6/R7 random", h, m, rd, wr);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule